// File: doc/BRIEF.md
# Bridge PWM Generator With Dead Time

This block produces the two alternating gate commands of a half-bridge or full-bridge converter. An internal counter ramp climbs through a charge phase of programmable length and falls back through a discharge phase of programmable length. The sum of the two is one oscillator period. Each oscillator period is given to one output only. The outputs take turns, so one full bridge switching cycle covers two oscillator periods. Both outputs stay low through the whole discharge phase, and that interval is the dead time between the two switches.

In the charge phase the active output goes high at the first cycle of the phase. It stays high while the ramp is below a limit level. The limit is the smaller of two values: the duty command and the soft-start word, each scaled by 4/5. The ramp runs from a valley code to a peak code, in a valley-to-peak ratio of 0.8 to 2.8. A limit at or below the valley gives no pulse. An overcurrent flag ends the current pulse at once. A one-cycle terminal strobe marks the last cycle of every discharge phase, so that current-sense blanking and a soft-start sequencer can be stepped from it.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `bridge_pwm_core`

## Requirements
- R1: While enabled, each oscillator period lasts max(chg_len,1) + max(dis_len,1) clock cycles. The lengths are taken from the inputs in the first cycle of each charge phase and hold for that whole period.
- R2: out_a and out_b are never high in the same cycle.
- R3: Both outputs are low in every cycle of the discharge phase.
- R4: After reset or after en rises, the first charge phase drives out_a. Successive oscillator periods then alternate between out_b and out_a.
- R5: Let L = min(floor(4*duty_cmd/5), floor(4*soft_lvl/5)), V = floor(2*PEAK/7) and S = PEAK - V. Let C be the latched charge length, and let t count the charge cycles from 0. The active output is high in cycle t exactly when S*t < (L-V)*C and no overcurrent has cut the pulse. If L is at or above PEAK, the pulse fills the whole charge phase.
- R6: When L <= V, neither output goes high at any point in the period (zero duty).
- R7: While oc is high, both outputs are low in that same cycle. A pulse cut by oc stays low until the next charge phase starts.
- R8: While en is low, both outputs and cyc_end are low. The ramp then restarts at the start of a charge phase, with out_a leading.
- R9: cyc_end is high for exactly one cycle, the last cycle of each discharge phase, and never in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global run enable |
| chg_len | input | DUR_W | Charge (ramp-up) length in cycles |
| dis_len | input | DUR_W | Discharge (dead time) length in cycles |
| duty_cmd | input | CODE_W | Duty command word |
| soft_lvl | input | CODE_W | Soft-start level word |
| oc | input | 1 | Overcurrent flag, synchronous |
| out_a | output | 1 | Gate command, phase A |
| out_b | output | 1 | Gate command, phase B |
| cyc_end | output | 1 | Terminal strobe on the last discharge cycle |

## Verification
The embedded properties assume that every input is synchronous to clk. They also assume that oc and en may change at any cycle, and that a zero length means one cycle rather than being illegal. The stimulus changes inputs only just after a rising edge. It covers zero lengths, limits below the valley and above the peak, single-cycle overcurrent hits inside a pulse, and enable drops in the middle of a period. With that stimulus the properties on overlap, dead time and strobe spacing are exercised in both phases and both steering states.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  typedef enum logic {PH_CHG = 1'b0, PH_DIS = 1'b1} phase_t;

  function automatic int valley_of(input int peak);
    return (peak * 2) / 7;
  endfunction
endpackage

// File: rtl/pwm_osc_timer.sv
module pwm_osc_timer
  import bpwm_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DUR_W-1:0] chg_len,
  input  logic [DUR_W-1:0] dis_len,
  output phase_t           phase,
  output logic [DUR_W-1:0] tcnt,
  output logic [DUR_W-1:0] chg_eff,
  output logic             steer,
  output logic             start,
  output logic             last_dis
);
  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  phase_t           ph_q;
  logic [DUR_W-1:0] tcnt_q, chg_q, dis_q;
  logic [DUR_W-1:0] chg_c, dis_c, dis_eff;
  logic             steer_q, last_chg;

  // zero lengths are promoted to one cycle
  assign chg_c    = (chg_len == '0) ? ONE : chg_len;
  assign dis_c    = (dis_len == '0) ? ONE : dis_len;
  assign start    = en && (ph_q == PH_CHG) && (tcnt_q == '0);
  assign chg_eff  = start ? chg_c : chg_q;
  assign dis_eff  = start ? dis_c : dis_q;
  assign last_chg = (ph_q == PH_CHG) && (tcnt_q == chg_eff - ONE);
  assign last_dis = en && (ph_q == PH_DIS) && (tcnt_q == dis_eff - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_CHG;
      tcnt_q  <= '0;
      chg_q   <= ONE;
      dis_q   <= ONE;
      steer_q <= 1'b0;
    end else if (!en) begin
      ph_q    <= PH_CHG;
      tcnt_q  <= '0;
      chg_q   <= ONE;
      dis_q   <= ONE;
      steer_q <= 1'b0;
    end else begin
      chg_q <= chg_eff;
      dis_q <= dis_eff;
      if (ph_q == PH_CHG) begin
        if (last_chg) begin
          ph_q   <= PH_DIS;
          tcnt_q <= '0;
        end else begin
          tcnt_q <= tcnt_q + ONE;
        end
      end else begin
        if (last_dis) begin
          ph_q    <= PH_CHG;
          tcnt_q  <= '0;
          steer_q <= ~steer_q;
        end else begin
          tcnt_q <= tcnt_q + ONE;
        end
      end
    end
  end

  assign phase = ph_q;
  assign tcnt  = tcnt_q;
  assign steer = steer_q;

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_dis |=> !last_dis) else $error("strobe repeated"); // R9
  AST_STEER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_dis && en) |=> (steer != $past(steer))) else $error("no alternation"); // R4
  AST_EN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == PH_CHG && tcnt == '0 && !steer)) else $error("no restart"); // R8
endmodule

// File: rtl/pwm_level_cmp.sv
module pwm_level_cmp #(
  parameter int CODE_W = 12,
  parameter int DUR_W  = 8,
  parameter int PEAK   = 1400
) (
  input  logic [CODE_W-1:0] duty_cmd,
  input  logic [CODE_W-1:0] soft_lvl,
  input  logic [DUR_W-1:0]  tcnt,
  input  logic [DUR_W-1:0]  chg_eff,
  output logic              below
);
  localparam int VALLEY = bpwm_pkg::valley_of(PEAK);
  localparam int SPAN   = PEAK - VALLEY;
  localparam int PROD_W = CODE_W + DUR_W + 1;
  localparam int X_W    = CODE_W + 3;

  logic [CODE_W-1:0] duty_s, soft_s, lvl, head;
  logic [PROD_W-1:0] ramp_term, lvl_term;
  logic              above_valley;

  function automatic logic [CODE_W-1:0] scale45(input logic [CODE_W-1:0] v);
    logic [X_W-1:0] x4;
    x4 = {1'b0, v, 2'b00};
    return CODE_W'(x4 / X_W'(5));
  endfunction

  assign duty_s       = scale45(duty_cmd);
  assign soft_s       = scale45(soft_lvl);
  assign lvl          = (duty_s < soft_s) ? duty_s : soft_s;
  assign above_valley = lvl > CODE_W'(VALLEY);
  assign head         = above_valley ? (lvl - CODE_W'(VALLEY)) : '0;
  assign ramp_term    = PROD_W'(SPAN) * PROD_W'(tcnt);
  assign lvl_term     = PROD_W'(head) * PROD_W'(chg_eff);
  assign below        = above_valley && (ramp_term < lvl_term);
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import bpwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  phase_t phase,
  input  logic   start,
  input  logic   below,
  input  logic   oc,
  input  logic   steer,
  output logic   out_a,
  output logic   out_b
);
  logic       held_q, live, pulse;
  logic [1:0] drv;

  assign live  = en && (phase == PH_CHG) && (start || held_q);
  assign pulse = live && below && !oc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         held_q <= 1'b0;
    else if (!en || phase != PH_CHG)    held_q <= 1'b0;
    else                                held_q <= pulse;
  end

  for (genvar i = 0; i < 2; i++) begin : g_chan
    assign drv[i] = pulse && (steer == 1'(i));
  end

  assign out_a = drv[0];
  assign out_b = drv[1];

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b)) else $error("overlap"); // R2
  AST_DEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DIS) |-> !(out_a || out_b)) else $error("drive in dead time"); // R3
  AST_OC_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    oc |-> !(out_a || out_b)) else $error("drive during overcurrent"); // R7
  AST_OC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oc && phase == PH_CHG && !start) |=> (start || !(out_a || out_b))) else $error("pulse revived"); // R7
  AST_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(out_a || out_b)) else $error("drive while disabled"); // R8
endmodule

// File: rtl/bridge_pwm_core.sv
module bridge_pwm_core
  import bpwm_pkg::*;
#(
  parameter int DUR_W  = 8,
  parameter int CODE_W = 12,
  parameter int PEAK   = 1400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DUR_W-1:0]  chg_len,
  input  logic [DUR_W-1:0]  dis_len,
  input  logic [CODE_W-1:0] duty_cmd,
  input  logic [CODE_W-1:0] soft_lvl,
  input  logic              oc,
  output logic              out_a,
  output logic              out_b,
  output logic              cyc_end
);
  phase_t           phase;
  logic [DUR_W-1:0] tcnt, chg_eff;
  logic             steer, start, below, last_dis;

  pwm_osc_timer #(.DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .chg_len(chg_len), .dis_len(dis_len),
    .phase(phase), .tcnt(tcnt), .chg_eff(chg_eff), .steer(steer),
    .start(start), .last_dis(last_dis)
  );

  pwm_level_cmp #(.CODE_W(CODE_W), .DUR_W(DUR_W), .PEAK(PEAK)) u_cmp (
    .duty_cmd(duty_cmd), .soft_lvl(soft_lvl), .tcnt(tcnt),
    .chg_eff(chg_eff), .below(below)
  );

  pwm_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .start(start),
    .below(below), .oc(oc), .steer(steer), .out_a(out_a), .out_b(out_b)
  );

  assign cyc_end = last_dis;

  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> !(out_a || out_b)) else $error("strobe during pulse"); // R9
endmodule

// File: tb/sim_bridge_pwm_core.sv
module sim_bridge_pwm_core;
  localparam int DUR_W  = 8;
  localparam int CODE_W = 12;
  localparam int PEAK   = 1400;
  localparam int VAL    = (PEAK * 2) / 7;
  localparam int SPN    = PEAK - VAL;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, oc = 1'b0;
  logic [DUR_W-1:0]  chg_len = '0, dis_len = '0;
  logic [CODE_W-1:0] duty_cmd = '0, soft_lvl = '0;
  logic out_a, out_b, cyc_end;

  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct { bit a; bit b; bit e; string tag; } exp_t;
  exp_t q[$];

  // reference state, described from the requirements
  int  m_ph = 0, m_t = 0, m_c = 1, m_d = 1;
  bit  m_st = 0, m_held = 0;

  always #4 clk = ~clk;

  bridge_pwm_core #(.DUR_W(DUR_W), .CODE_W(CODE_W), .PEAK(PEAK)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .chg_len(chg_len), .dis_len(dis_len),
    .duty_cmd(duty_cmd), .soft_lvl(soft_lvl), .oc(oc),
    .out_a(out_a), .out_b(out_b), .cyc_end(cyc_end)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit e, input int c, input int d, input int du, input int ss,
                      input bit o, input string tag);
    exp_t it;
    int cc, dd, l1, l2, lv;
    bit ok, live, pulse;
    @(posedge clk); #1;
    en = e; chg_len = DUR_W'(c); dis_len = DUR_W'(d);
    duty_cmd = CODE_W'(du); soft_lvl = CODE_W'(ss); oc = o;
    it.tag = tag;
    if (!e) begin
      it.a = 0; it.b = 0; it.e = 0;
      m_ph = 0; m_t = 0; m_st = 0; m_held = 0;
    end else begin
      cc = (m_ph == 0 && m_t == 0) ? ((c == 0) ? 1 : c) : m_c;
      dd = (m_ph == 0 && m_t == 0) ? ((d == 0) ? 1 : d) : m_d;
      m_c = cc; m_d = dd;
      l1 = (du * 4) / 5; l2 = (ss * 4) / 5;
      lv = (l1 < l2) ? l1 : l2;
      ok = (lv > VAL) && (SPN * m_t < (lv - VAL) * cc);
      live = (m_ph == 0) && (m_t == 0 || m_held);
      pulse = live && ok && !o;
      it.a = pulse && !m_st; it.b = pulse && m_st;
      it.e = (m_ph == 1) && (m_t == dd - 1);
      if (m_ph == 0) begin
        m_held = pulse;
        if (m_t == cc - 1) begin m_ph = 1; m_t = 0; end else m_t++;
      end else begin
        m_held = 0;
        if (m_t == dd - 1) begin m_ph = 0; m_t = 0; m_st = ~m_st; end else m_t++;
      end
    end
    q.push_back(it);
  endtask

  task automatic seg(input int n, input int c, input int d, input int du, input int ss,
                     input int oc_at, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, c, d, du, ss, i == oc_at, tag);
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check(out_a == it.a, it.tag, "out_a", int'(out_a), int'(it.a));
      check(out_b == it.b, it.tag, "out_b", int'(out_b), int'(it.b));
      check(cyc_end == it.e, {it.tag, " R9"}, "cyc_end", int'(cyc_end), int'(it.e));
      check(!(out_a && out_b), "R2", "overlap", 1, 0);
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!out_a && !out_b && !cyc_end, "R8", "reset outputs", int'({out_a, out_b, cyc_end}), 0);
    rst_n = 1'b1;
    // R1 R4 R5: full duty, 10 charge + 3 dead cycles, A then B
    seg(60, 10, 3, 4095, 4095, -1, "R1 R4 R5 full");
    // R5: duty limit 900 -> 5 cycle pulses
    seg(40, 10, 3, 1125, 4095, -1, "R5 duty");
    // R5: soft-start limit 1000 -> 6 cycle pulses
    seg(40, 10, 3, 4095, 1250, -1, "R5 softstart");
    // R6: limit exactly at valley -> no pulse
    seg(30, 8, 2, 500, 4095, -1, "R6 zero");
    seg(30, 8, 2, 4095, 300, -1, "R6 zero ss");
    // R8: disable mid period, then A leads again
    seg(7, 10, 3, 4095, 4095, -1, "R8 pre");
    for (int i = 0; i < 6; i++) step(1'b0, 10, 3, 4095, 4095, 1'b0, "R8 off");
    seg(30, 10, 3, 4095, 4095, -1, "R8 R4 restart");
    // R7: overcurrent hit inside pulse, pulse stays cut
    seg(40, 8, 4, 4095, 4095, 3, "R7 oc");
    seg(30, 8, 4, 4095, 4095, 13, "R7 oc B");
    // R1: zero lengths become one cycle each
    seg(20, 0, 0, 4095, 4095, -1, "R1 zero len");
    // R1 R3: long dead time, mid-scale duty
    seg(60, 6, 9, 1500, 1600, -1, "R1 R3 long dead");
    repeat (2) @(posedge clk);
    #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule